// File: doc/BRIEF.md
# Address-Bound Line Integrity Checker

This block sits on the path between a cache controller and external memory and guards every data line that crosses it. When a dirty line is evicted, the block computes a signature for it and stores that signature in a separate region of memory, after the line itself. When a line is filled, the block reads the line and its stored signature, recomputes the signature over what arrived, and forwards the line only when the two agree.

The signature is a CRC-32. Its input is a 32-bit label followed by the line contents. The label is the line's start address measured from a program base address, and it is never written to memory. A line that is correctly signed but is replayed at a different address therefore fails the check. Any failed check raises a tamper alarm that stays set until reset. Encryption is not part of this block: line data passes through unchanged.

Top module: `line_guard`

## Requirements
- R1: The signature is a CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. There is no reflection and no final inversion. Bits are fed most significant first: the 32-bit label, then beat 0 through the last beat. Beat k is bits [32k+31:32k] of the line.
- R2: The label equals the line-aligned request address minus `prog_base`, modulo 2^32. The low address bits inside a line are ignored.
- R3: The signature word for a line is at byte address `SIG_BASE + 4*(line_addr / LINE_BYTES)`.
- R4: A write-back writes beat k to `line_addr + 4k` in ascending order of k, and then writes the signature word. It responds with `rsp_err` low.
- R5: A fill reads the beats in ascending order and then the signature word. If the recomputed signature matches, it returns the line on `rsp_line` with `rsp_err` low.
- R6: If a fill's signature does not match, the response carries `rsp_err` high and `rsp_line` all zero. This covers altered data and a line substituted from another address.
- R7: `tamper` goes high the cycle after a mismatching response and stays high until reset, including across later good fills.
- R8: Only one request is in flight at a time. `req_ready` is low from the cycle after a request is accepted until the response has been given.
- R9: After reset, `req_ready` is high and `tamper`, `mem_req` and `rsp_valid` are low.
- R10: The signature is computed in the same cycle the last memory access completes. `rsp_valid` is high for exactly the one cycle that follows the final `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_base | input | 32 | Program base address used to form the label |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_write | input | 1 | 1 = write-back, 0 = fill |
| req_addr | input | 32 | Byte address inside the line |
| req_line | input | LINE_BYTES*8 | Line to write back |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Fill failed its integrity check |
| rsp_line | output | LINE_BYTES*8 | Line returned by a fill (zero on error) |
| tamper | output | 1 | Sticky tamper alarm |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the memory word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume the memory raises `mem_ack` only while `mem_req` is high. They also assume it keeps at most one access outstanding, and that a requester keeps `req_write`, `req_addr` and `req_line` steady during the accepting cycle. The bench's memory model acknowledges each request exactly once, on the edge after it first sees that request. Requests are applied for a single cycle at a falling edge, only while `req_ready` is high. Tampering is done by changing the model's stored words between transactions, never while the block is using memory.

// File: rtl/line_guard.sv
module line_guard #(
  parameter int          LINE_BYTES = 32,
  parameter logic [31:0] SIG_BASE   = 32'h8000_0000,
  parameter logic [31:0] POLY       = 32'h04C1_1DB7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [31:0]             prog_base,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [31:0]             req_addr,
  input  logic [LINE_BYTES*8-1:0] req_line,
  output logic                    rsp_valid,
  output logic                    rsp_err,
  output logic [LINE_BYTES*8-1:0] rsp_line,
  output logic                    tamper,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [31:0]             mem_addr,
  output logic [31:0]             mem_wdata,
  input  logic                    mem_ack,
  input  logic [31:0]             mem_rdata
);
  localparam int BEATS = LINE_BYTES / 4;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int BW    = OFF_W - 2;
  localparam int IW    = $clog2(BEATS + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE} st_t;

  st_t         st;
  logic        wr_q;
  logic [31:0] laddr_q, label_q, sig_q;
  logic [IW-1:0] idx;
  logic [31:0] beat_q [BEATS];
  logic [31:0] calc;

  wire          at_sig = (idx == IW'(BEATS));
  wire [BW-1:0] bidx   = idx[BW-1:0];
  wire [31:0]   aligned = {req_addr[31:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    calc = 32'hFFFF_FFFF;
    for (int i = 31; i >= 0; i--)
      calc = {calc[30:0], 1'b0} ^ ((calc[31] ^ label_q[i]) ? POLY : 32'h0);
    for (int k = 0; k < BEATS; k++)
      for (int i = 31; i >= 0; i--)
        calc = {calc[30:0], 1'b0} ^ ((calc[31] ^ beat_q[k][i]) ? POLY : 32'h0);
  end

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_XFER);
  assign mem_we    = wr_q;
  assign mem_addr  = at_sig ? SIG_BASE + ((laddr_q >> OFF_W) << 2)
                            : laddr_q + {{(30-IW){1'b0}}, idx, 2'b00};
  assign mem_wdata = at_sig ? calc : beat_q[bidx];
  assign rsp_valid = (st == S_DONE);
  assign rsp_err   = rsp_valid && !wr_q && (calc != sig_q);

  for (genvar k = 0; k < BEATS; k++) begin : g_out
    assign rsp_line[32*k +: 32] = rsp_err ? 32'h0 : beat_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      wr_q <= 1'b0;
      laddr_q <= '0;
      label_q <= '0;
      sig_q <= '0;
      idx <= '0;
      tamper <= 1'b0;
      for (int k = 0; k < BEATS; k++) beat_q[k] <= '0;
    end else begin
      if (rsp_err) tamper <= 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          laddr_q <= aligned;
          label_q <= aligned - prog_base;
          idx     <= '0;
          if (req_write)
            for (int k = 0; k < BEATS; k++) beat_q[k] <= req_line[32*k +: 32];
          st <= S_XFER;
        end
        S_XFER: if (mem_ack) begin
          if (at_sig) begin
            if (!wr_q) sig_q <= mem_rdata;
            st <= S_DONE;
          end else begin
            if (!wr_q) beat_q[bidx] <= mem_rdata;
            idx <= idx + IW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_alarm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tamper |=> tamper);
  p_err_raises_alarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> tamper);
  p_err_hides_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_line == '0));
  p_one_at_a_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_rsp_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(mem_ack) && !mem_req));
  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_write_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && mem_we) |-> !rsp_err);
endmodule

// File: tb/line_guard_bench.sv
module line_guard_bench;
  localparam int LINE_BYTES = 32;
  localparam int LB = LINE_BYTES * 8;
  localparam int BEATS = LINE_BYTES / 4;
  localparam logic [31:0] SIGB = 32'h8000_0000;

  logic clk = 0, rst_n = 0;
  logic [31:0] prog_base = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0;
  logic [LB-1:0] req_line = '0;
  logic req_ready, rsp_valid, rsp_err, tamper, mem_req, mem_we, mem_ack = 0;
  logic [LB-1:0] rsp_line;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;

  always #2 clk = ~clk;

  line_guard #(.LINE_BYTES(LINE_BYTES), .SIG_BASE(SIGB)) u_line_guard (
    .clk(clk), .rst_n(rst_n), .prog_base(prog_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_line(rsp_line), .tamper(tamper),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  logic [31:0] store [logic [31:0]];
  logic [31:0] wl_addr [16];
  logic [31:0] wl_data [16];
  int wn = 0;

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        store[mem_addr] = mem_wdata;
        if (wn < 16) begin wl_addr[wn] = mem_addr; wl_data[wn] = mem_wdata; end
        wn = wn + 1;
      end else
        mem_rdata <= store.exists(mem_addr) ? store[mem_addr] : 32'h0;
    end else
      mem_ack <= 1'b0;
  end

  int total = 0, failed = 0;
  logic got_err;
  logic [LB-1:0] got_line;
  int lat;

  task automatic chk(input bit ok, input string tag, input logic [LB-1:0] act, input logic [LB-1:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_sig(input logic [31:0] lbl, input logic [LB-1:0] ln);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 31; i >= 0; i--)
      c = {c[30:0], 1'b0} ^ ((c[31] ^ lbl[i]) ? 32'h04C1_1DB7 : 32'h0);
    for (int k = 0; k < BEATS; k++)
      for (int i = 31; i >= 0; i--)
        c = {c[30:0], 1'b0} ^ ((c[31] ^ ln[32*k+i]) ? 32'h04C1_1DB7 : 32'h0);
    return c;
  endfunction

  function automatic logic [LB-1:0] pattern(input logic [31:0] a, input int s);
    logic [LB-1:0] l;
    for (int k = 0; k < BEATS; k++)
      l[32*k +: 32] = (a * 32'h9E37_79B1) ^ (32'(k) * 32'h0101_0101) ^ 32'(s * 7919);
    return l;
  endfunction

  task automatic do_req(input bit w, input logic [31:0] a, input logic [LB-1:0] ln);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_line = ln;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R8 ready low after accept", LB'(req_ready), 0);
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    got_err = rsp_err; got_line = rsp_line;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 response lasts one cycle", LB'(rsp_valid), 0);
  endtask

  task automatic reset_dut();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R9 ready after reset", LB'(req_ready), 1);
    chk(tamper == 0, "R9 tamper after reset", LB'(tamper), 0);
    chk(mem_req == 0, "R9 mem_req after reset", LB'(mem_req), 0);
    chk(rsp_valid == 0, "R9 rsp_valid after reset", LB'(rsp_valid), 0);

    for (int b = 0; b < 2; b++) begin
      for (int n = 0; n < 4; n++) begin
        logic [31:0] a, la, lbl, sgad;
        logic [LB-1:0] ln;
        prog_base = (b == 0) ? 32'h0 : 32'h0000_1000;
        a = 32'h0000_2000 + 32'(n) * 32'h460 + 32'(n * 4);
        la = {a[31:5], 5'b0};
        lbl = la - prog_base;
        sgad = SIGB + ((la >> 5) << 2);
        ln = pattern(a, b);
        wn = 0;
        do_req(1'b1, a, ln);
        chk(wn == BEATS + 1, "R4 write count", LB'(wn), LB'(BEATS + 1));
        chk(got_err == 0, "R4 write-back no error", LB'(got_err), 0);
        for (int k = 0; k < BEATS; k++) begin
          chk(wl_addr[k] == la + 32'(4 * k), "R4 beat address order", LB'(wl_addr[k]), LB'(la + 32'(4 * k)));
          chk(wl_data[k] == ln[32*k +: 32], "R4 beat data", LB'(wl_data[k]), LB'(ln[32*k +: 32]));
        end
        chk(wl_addr[BEATS] == sgad, "R3 signature address", LB'(wl_addr[BEATS]), LB'(sgad));
        chk(wl_data[BEATS] == ref_sig(lbl, ln), "R1 R2 signature value", LB'(wl_data[BEATS]), LB'(ref_sig(lbl, ln)));
        do_req(1'b0, a, '0);
        chk(got_err == 0, "R5 fill accepted", LB'(got_err), 0);
        chk(got_line == ln, "R5 fill data", got_line, ln);
        chk(lat == 2 * (BEATS + 1) + 1, "R10 fill latency", LB'(lat), LB'(2 * (BEATS + 1) + 1));
        chk(tamper == 0, "R7 no alarm on good fill", LB'(tamper), 0);
      end
    end

    prog_base = 32'h0000_1000;
    store[32'h0000_2004] = store[32'h0000_2004] ^ 32'h0000_0100;
    do_req(1'b0, 32'h0000_2000, '0);
    chk(got_err == 1, "R6 altered data flagged", LB'(got_err), 1);
    chk(got_line == '0, "R6 rejected line zeroed", got_line, '0);
    chk(tamper == 1, "R7 alarm raised", LB'(tamper), 1);
    do_req(1'b0, 32'h0000_2460, '0);
    chk(got_err == 0, "R5 later good fill", LB'(got_err), 0);
    chk(tamper == 1, "R7 alarm sticky", LB'(tamper), 1);

    reset_dut();
    chk(tamper == 0, "R7 alarm cleared by reset", LB'(tamper), 0);
    prog_base = 32'h0;
    for (int k = 0; k < BEATS; k++)
      store[32'h0000_3000 + 32'(4 * k)] = store[32'h0000_28C0 + 32'(4 * k)];
    store[SIGB + ((32'h3000 >> 5) << 2)] = store[SIGB + ((32'h28C0 >> 5) << 2)];
    do_req(1'b0, 32'h0000_3000, '0);
    chk(got_err == 1, "R6 substituted line flagged", LB'(got_err), 1);
    chk(tamper == 1, "R7 alarm after substitution", LB'(tamper), 1);

    reset_dut();
    prog_base = 32'h0;
    do_req(1'b1, 32'h0000_4000, pattern(32'h4000, 5));
    prog_base = 32'h0000_0100;
    do_req(1'b0, 32'h0000_4000, '0);
    chk(got_err == 1, "R2 base change alters label", LB'(got_err), 1);
    prog_base = 32'h0;
    reset_dut();
    do_req(1'b0, 32'h0000_401C, '0);
    chk(got_err == 0, "R2 offset bits ignored", LB'(got_err), 0);
    chk(got_line == pattern(32'h4000, 5), "R5 fill after reset", got_line, pattern(32'h4000, 5));

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule